// File: doc/BRIEF.md
# Clock Mode Switching Controller

This controller picks which of three sources drives the processor clock: a slow sub oscillator, the main oscillator, or a PLL that multiplies the main oscillator. Software sets a 2-bit mode request and a 2-bit wait-select field. The controller turns the oscillators and the PLL on and off and runs a stabilization wait before each source becomes usable. It moves the selected source only when that wait has finished. The source oscillators are modelled as single-cycle enable ticks in the system clock domain, and every wait counts those ticks.

The length of a wait depends on where a switch starts. Going from the main clock to the PLL costs a fixed count, because the oscillator is already running. Going from the sub clock to the PLL, or leaving the PLL stop state, starts the main oscillator and the PLL together, and one count covers both. Software chooses that length, with a floor that keeps the PLL safe. Two status bits show the source that is actually in use. While a transition is in progress, new mode changes and stop requests are held off or dropped.

Top module: `clkmode_ctrl`

## Requirements
- R1: After synchronous reset the main clock is selected (`src_sel` = 00), `main_osc_en` = 1, `pll_en` = 0, `sub_osc_en` = 1, both status bits are 0 and `switch_done` is 0.
- R2: Main to PLL (mode code 01 requested while on main, code 00): `pll_en` rises at the start edge, `src_sel` stays at main, and the switch completes on the 2^PLL_MIN_LOG2-th `main_tick` whatever the wait-select value.
- R3: Sub to PLL: `main_osc_en` and `pll_en` rise together, and one wait runs for max(2^(WS_BASE_LOG2 + 2*wait_sel), 2^PLL_MIN_LOG2) `main_tick`s.
- R4: Sub to main (code 00): `main_osc_en` rises and the switch completes after 2^(WS_BASE_LOG2 + 2*wait_sel) `main_tick`s, with `pll_en` staying 0.
- R5: A switch to sub (code 10) from main or PLL completes on the next `sub_tick`. At that point `main_osc_en` and `pll_en` drop to 0.
- R6: PLL to main completes on the next `main_tick`, and `pll_en` drops to 0 at that point.
- R7: A stop request in sub mode clears `sub_osc_en`. Mode requests are ignored while stopped. A wake request sets `sub_osc_en` again and returns to sub after 2^SUB_WAIT_LOG2 `sub_tick`s.
- R8: A stop request in PLL mode clears `main_osc_en` and `pll_en`. A wake request sets both again and returns to PLL after the same floored wait as R3.
- R9: A stop request in main mode clears `main_osc_en` only. A wake request returns to main after 2^(WS_BASE_LOG2 + 2*wait_sel) `main_tick`s, with no floor.
- R10: A mode request that changes during a transition does not alter its target. The new level is acted on only after completion. Request code 11 never starts a transition.
- R11: A stop request is ignored during a transition, and also when the request level differs from the current source. A wake request is ignored unless the controller is stopped.
- R12: `src_sel` changes only together with a one-cycle `switch_done` pulse. `stat_pll` is 1 exactly when the PLL is selected, `stat_sub` is 1 exactly when the sub clock is selected, and the two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 2 | Requested source: 00 main, 01 PLL, 10 sub, 11 no request |
| wait_sel | input | 2 | Stabilization length select, sampled at the start of a wait |
| stop_req | input | 1 | Single-cycle request to enter the stop state of the current mode |
| wake_req | input | 1 | Single-cycle request to leave the stop state |
| sub_tick | input | 1 | Enable tick, one per sub oscillator period |
| main_tick | input | 1 | Enable tick, one per main oscillator period |
| src_sel | output | 2 | Selected source, same encoding as `mode_req` |
| main_osc_en | output | 1 | Main oscillator enable |
| pll_en | output | 1 | PLL enable |
| sub_osc_en | output | 1 | Sub oscillator enable |
| stat_pll | output | 1 | Status: PLL is the active source |
| stat_sub | output | 1 | Status: sub clock is the active source |
| switch_done | output | 1 | One-cycle pulse when a switch or wake completes |

## Verification
The bench builds the controller with WS_BASE_LOG2 = 2, SUB_WAIT_LOG2 = 4 and PLL_MIN_LOG2 = 6. This gives wait-select lengths of 4, 16, 64 and 256 ticks, a PLL floor of 64 and a sub wake wait of 16. With these values every wait-select code, both sides of the floor and every start point of a switch run in a few hundred cycles. The ticks of each wait are counted exactly. Requests are also injected part-way through long waits, to show that they are held off or dropped.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    typedef enum logic [1:0] {
        SRC_MAIN = 2'b00,
        SRC_PLL  = 2'b01,
        SRC_SUB  = 2'b10,
        SRC_NONE = 2'b11
    } clk_src_e;

    typedef enum logic [1:0] {
        ST_RUN    = 2'b00,
        ST_SWITCH = 2'b01,
        ST_STOP   = 2'b10,
        ST_WAKE   = 2'b11
    } seq_state_e;

    typedef struct packed {
        logic main_en;
        logic pll_en;
        logic sub_en;
    } osc_en_t;

    localparam osc_en_t OSC_RESET = '{main_en: 1'b1, pll_en: 1'b0, sub_en: 1'b1};

    // log2 of the software-selected wait, four codes spaced by a factor of four
    function automatic int unsigned ws_len(input logic [1:0] ws, input int unsigned base);
        return base + 2 * int'(ws);
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/clkmode_waitctr.sv
module clkmode_waitctr #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] len_log2,
    input  logic             tick,
    output logic             running,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic             run_q;
    logic [CNT_W:0]   last_w;

    assign last_w  = ((CNT_W+1)'(1) << len_q) - 1'b1;
    assign expire  = run_q && tick && (cnt_q == last_w[CNT_W-1:0]);
    assign running = run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            len_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            len_q <= len_log2;
        end else if (expire) begin
            run_q <= 1'b0;
        end else if (run_q && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/clkmode_seq.sv
module clkmode_seq
    import clkmode_pkg::*;
#(
    parameter int unsigned WS_BASE_LOG2  = 10,
    parameter int unsigned SUB_WAIT_LOG2 = 14,
    parameter int unsigned PLL_MIN_LOG2  = 14,
    parameter int unsigned LEN_W         = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_req,
    input  logic [1:0]       wait_sel,
    input  logic             stop_req,
    input  logic             wake_req,
    input  logic             ctr_expire,
    output logic             ctr_start,
    output logic [LEN_W-1:0] ctr_len,
    output logic             tick_sub,
    output clk_src_e         src,
    output osc_en_t          osc_en,
    output logic             done
);
    seq_state_e  st_q, st_d;
    clk_src_e    src_q, src_d, tgt_q, tgt_d, req;
    osc_en_t     en_q, en_d;
    logic        sub_q, sub_d, done_q;
    int unsigned len_i, ws_l, pll_l;

    always_comb begin
        st_d      = st_q;
        src_d     = src_q;
        tgt_d     = tgt_q;
        en_d      = en_q;
        sub_d     = sub_q;
        ctr_start = 1'b0;
        len_i     = 0;
        req       = clk_src_e'(mode_req);
        ws_l      = ws_len(wait_sel, WS_BASE_LOG2);
        pll_l     = max_u(ws_l, PLL_MIN_LOG2);
        unique case (st_q)
            ST_RUN: begin
                if (req != SRC_NONE && req != src_q) begin
                    ctr_start = 1'b1;
                    st_d      = ST_SWITCH;
                    tgt_d     = req;
                    case (req)
                        SRC_PLL: begin
                            sub_d          = 1'b0;
                            en_d.main_en   = 1'b1;
                            en_d.pll_en    = 1'b1;
                            len_i          = (src_q == SRC_SUB) ? pll_l : PLL_MIN_LOG2;
                        end
                        SRC_MAIN: begin
                            sub_d = 1'b0;
                            if (src_q == SRC_SUB) begin
                                en_d.main_en = 1'b1;
                                len_i        = ws_l;
                            end
                        end
                        default: begin
                            sub_d = 1'b1;
                        end
                    endcase
                end else if (stop_req) begin
                    st_d = ST_STOP;
                    if (src_q == SRC_SUB) begin
                        en_d.sub_en = 1'b0;
                    end else begin
                        en_d.main_en = 1'b0;
                        en_d.pll_en  = 1'b0;
                    end
                end
            end
            ST_STOP: begin
                if (wake_req) begin
                    ctr_start = 1'b1;
                    st_d      = ST_WAKE;
                    case (src_q)
                        SRC_SUB: begin
                            sub_d       = 1'b1;
                            en_d.sub_en = 1'b1;
                            len_i       = SUB_WAIT_LOG2;
                        end
                        SRC_PLL: begin
                            sub_d        = 1'b0;
                            en_d.main_en = 1'b1;
                            en_d.pll_en  = 1'b1;
                            len_i        = pll_l;
                        end
                        default: begin
                            sub_d        = 1'b0;
                            en_d.main_en = 1'b1;
                            len_i        = ws_l;
                        end
                    endcase
                end
            end
            ST_SWITCH: begin
                if (ctr_expire) begin
                    st_d  = ST_RUN;
                    src_d = tgt_q;
                    if (tgt_q == SRC_SUB) begin
                        en_d.main_en = 1'b0;
                        en_d.pll_en  = 1'b0;
                    end else if (tgt_q == SRC_MAIN) begin
                        en_d.pll_en = 1'b0;
                    end
                end
            end
            default: begin
                if (ctr_expire) begin
                    st_d = ST_RUN;
                end
            end
        endcase
        ctr_len = LEN_W'(len_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_RUN;
            src_q  <= SRC_MAIN;
            tgt_q  <= SRC_MAIN;
            en_q   <= OSC_RESET;
            sub_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            src_q  <= src_d;
            tgt_q  <= tgt_d;
            en_q   <= en_d;
            sub_q  <= sub_d;
            done_q <= ctr_expire && (st_q == ST_SWITCH || st_q == ST_WAKE);
        end
    end

    assign tick_sub = sub_q;
    assign src      = src_q;
    assign osc_en   = en_q;
    assign done     = done_q;
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
    import clkmode_pkg::*;
#(
    parameter int unsigned WS_BASE_LOG2  = 10,
    parameter int unsigned SUB_WAIT_LOG2 = 14,
    parameter int unsigned PLL_MIN_LOG2  = 14
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_req,
    input  logic [1:0] wait_sel,
    input  logic       stop_req,
    input  logic       wake_req,
    input  logic       sub_tick,
    input  logic       main_tick,
    output logic [1:0] src_sel,
    output logic       main_osc_en,
    output logic       pll_en,
    output logic       sub_osc_en,
    output logic       stat_pll,
    output logic       stat_sub,
    output logic       switch_done
);
    localparam int unsigned MAX_LOG2 = max_u(max_u(WS_BASE_LOG2 + 6, SUB_WAIT_LOG2), PLL_MIN_LOG2);
    localparam int unsigned CNT_W    = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;
    localparam int unsigned LEN_W    = $clog2(MAX_LOG2 + 1);

    logic             ctr_start, ctr_expire, ctr_running, tick_sub, tick_mux;
    logic [LEN_W-1:0] ctr_len;
    clk_src_e         src;
    osc_en_t          osc_en;

    assign tick_mux = tick_sub ? sub_tick : main_tick;

    clkmode_seq #(
        .WS_BASE_LOG2 (WS_BASE_LOG2),
        .SUB_WAIT_LOG2(SUB_WAIT_LOG2),
        .PLL_MIN_LOG2 (PLL_MIN_LOG2),
        .LEN_W        (LEN_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .mode_req  (mode_req),
        .wait_sel  (wait_sel),
        .stop_req  (stop_req),
        .wake_req  (wake_req),
        .ctr_expire(ctr_expire),
        .ctr_start (ctr_start),
        .ctr_len   (ctr_len),
        .tick_sub  (tick_sub),
        .src       (src),
        .osc_en    (osc_en),
        .done      (switch_done)
    );

    clkmode_waitctr #(
        .CNT_W(CNT_W),
        .LEN_W(LEN_W)
    ) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .start   (ctr_start),
        .len_log2(ctr_len),
        .tick    (tick_mux),
        .running (ctr_running),
        .expire  (ctr_expire)
    );

    assign src_sel     = src;
    assign main_osc_en = osc_en.main_en;
    assign pll_en      = osc_en.pll_en;
    assign sub_osc_en  = osc_en.sub_en;
    assign stat_pll    = (src == SRC_PLL);
    assign stat_sub    = (src == SRC_SUB);
endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] src_sel,
    input logic       main_osc_en,
    input logic       pll_en,
    input logic       stat_pll,
    input logic       stat_sub,
    input logic       switch_done
);
    AST_PLL_READY_ON_SELECT: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_pll) |-> (pll_en && main_osc_en)); // R2

    AST_SUB_STOPS_FAST_CLOCKS: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_sub) |-> (!main_osc_en && !pll_en)); // R5

    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        switch_done |=> !switch_done); // R12

    AST_SRC_MOVES_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(src_sel) |-> switch_done); // R12

    AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(stat_pll && stat_sub)); // R12

    AST_NO_RESERVED_SOURCE: assert property (@(posedge clk) disable iff (rst)
        src_sel != 2'b11); // R10
endmodule

bind clkmode_ctrl clkmode_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .src_sel    (src_sel),
    .main_osc_en(main_osc_en),
    .pll_en     (pll_en),
    .stat_pll   (stat_pll),
    .stat_sub   (stat_sub),
    .switch_done(switch_done)
);

// File: tb/clkmode_ctrl_bench.sv
module clkmode_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAIN = 0, PLL = 1, SUB = 2;

    // entry: {request[15:14], wait_sel[13:12], sub-tick wait[11], tick count[10:0]}
    localparam logic [15:0] TBL [0:13] = '{
        {2'd1, 2'd0, 1'b0, 11'd64},   // R2 main to PLL
        {2'd2, 2'd0, 1'b1, 11'd1},    // R5 PLL to sub
        {2'd1, 2'd0, 1'b0, 11'd64},   // R3 floor applies
        {2'd0, 2'd0, 1'b0, 11'd1},    // R6 PLL to main
        {2'd2, 2'd0, 1'b1, 11'd1},    // R5 main to sub
        {2'd0, 2'd0, 1'b0, 11'd4},    // R4 code 00
        {2'd2, 2'd0, 1'b1, 11'd1},    // R5
        {2'd0, 2'd1, 1'b0, 11'd16},   // R4 code 01
        {2'd2, 2'd0, 1'b1, 11'd1},    // R5
        {2'd1, 2'd3, 1'b0, 11'd256},  // R3 code 11 above floor
        {2'd2, 2'd0, 1'b1, 11'd1},    // R5
        {2'd1, 2'd2, 1'b0, 11'd64},   // R3 code 10
        {2'd0, 2'd3, 1'b0, 11'd1},    // R6
        {2'd1, 2'd3, 1'b0, 11'd64}    // R2 fixed regardless of code
    };
    localparam int TBL_TAG [0:13] = '{2, 5, 3, 6, 5, 4, 5, 4, 5, 3, 5, 3, 6, 2};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_req = 2'd0;
    logic [1:0] wait_sel = 2'd0;
    logic       stop_req = 1'b0;
    logic       wake_req = 1'b0;
    logic       sub_tick = 1'b0;
    logic       main_tick = 1'b0;
    logic [1:0] src_sel;
    logic       main_osc_en, pll_en, sub_osc_en, stat_pll, stat_sub, switch_done;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        cyc       <= cyc + 1;
        main_tick <= (cyc % 2) == 0;
        sub_tick  <= (cyc % 3) == 0;
    end

    clkmode_ctrl #(
        .WS_BASE_LOG2 (2),
        .SUB_WAIT_LOG2(4),
        .PLL_MIN_LOG2 (6)
    ) u_clkmode_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mode_req   (mode_req),
        .wait_sel   (wait_sel),
        .stop_req   (stop_req),
        .wake_req   (wake_req),
        .sub_tick   (sub_tick),
        .main_tick  (main_tick),
        .src_sel    (src_sel),
        .main_osc_en(main_osc_en),
        .pll_en     (pll_en),
        .sub_osc_en (sub_osc_en),
        .stat_pll   (stat_pll),
        .stat_sub   (stat_sub),
        .switch_done(switch_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_src(input int exp, input string req);
        logic [2:0] en_exp;
        en_exp = (exp == PLL) ? 3'b111 : (exp == SUB) ? 3'b001 : 3'b101;
        check(src_sel == 2'(exp), {req, " source"}, src_sel, exp);
        check({main_osc_en, pll_en, sub_osc_en} == en_exp, {req, " enables"},
              {main_osc_en, pll_en, sub_osc_en}, en_exp);
        check({stat_pll, stat_sub} == {exp == PLL, exp == SUB}, {req, " status (R12)"},
              {stat_pll, stat_sub}, {exp == PLL, exp == SUB});
    endtask

    // kind: 0 set request, 1 wake pulse, 2 request plus stop pulse in the same cycle
    // mid_kind: 0 none, 1 change request to mid_val, 2 stop pulse
    task automatic run_wait(input int kind, input int req, input int ws, input bit use_sub,
                            input int exp_n, input int exp_src, input string tag,
                            input int mid_at, input int mid_kind, input int mid_val);
        int  n;
        int  it;
        bit  t;
        logic [1:0] prev;
        n    = 0;
        prev = src_sel;
        @(negedge clk);
        wait_sel = 2'(ws);
        if (kind == 1) wake_req = 1'b1;
        else mode_req = 2'(req);
        if (kind == 2) stop_req = 1'b1;
        @(posedge clk);
        #1;
        wake_req = 1'b0;
        stop_req = 1'b0;
        check(src_sel == prev, {tag, " source held during wait"}, src_sel, prev);
        for (it = 0; it < 2000; it++) begin
            @(negedge clk);
            #1;
            stop_req = 1'b0;
            if (it == mid_at && mid_kind == 1) mode_req = 2'(mid_val);
            if (it == mid_at && mid_kind == 2) stop_req = 1'b1;
            t = use_sub ? sub_tick : main_tick;
            @(posedge clk);
            if (t) n++;
            #1;
            if (switch_done) break;
        end
        stop_req = 1'b0;
        check(n == exp_n, {tag, " tick count"}, n, exp_n);
        check_src(exp_src, tag);
        @(posedge clk);
        #1;
        check(!switch_done, "R12 done lasts one cycle", switch_done, 0);
    endtask

    task automatic pulse_stop;
        @(negedge clk);
        stop_req = 1'b1;
        @(posedge clk);
        #1;
        stop_req = 1'b0;
    endtask

    task automatic hold_quiet(input int cycles, input int exp_src, input logic [2:0] en_exp,
                              input string tag);
        bit moved;
        moved = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            #1;
            if (switch_done || src_sel != 2'(exp_src) ||
                {main_osc_en, pll_en, sub_osc_en} != en_exp) moved = 1'b1;
        end
        check(!moved, tag, {src_sel, main_osc_en, pll_en, sub_osc_en},
              {2'(exp_src), en_exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL all requirements: watchdog expired actual=%0d expected=0", 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        check(!switch_done, "R1 done after reset", switch_done, 0);
        check_src(MAIN, "R1 reset");

        for (int r = 0; r < 14; r++) begin
            run_wait(0, int'(TBL[r][15:14]), int'(TBL[r][13:12]), TBL[r][11],
                     int'(TBL[r][10:0]), int'(TBL[r][15:14]),
                     $sformatf("R%0d row %0d", TBL_TAG[r], r), -1, 0, 0);
        end

        // R8: PLL stop and wake, floor then long code
        pulse_stop;
        check({main_osc_en, pll_en, sub_osc_en} == 3'b001, "R8 stop enables",
              {main_osc_en, pll_en, sub_osc_en}, 3'b001);
        run_wait(1, PLL, 0, 1'b0, 64, PLL, "R8 wake floored", -1, 0, 0);
        pulse_stop;
        run_wait(1, PLL, 3, 1'b0, 256, PLL, "R8 wake code 11", -1, 0, 0);

        // R11: wake while running is ignored
        @(negedge clk);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        hold_quiet(10, PLL, 3'b111, "R11 wake ignored while running");

        run_wait(0, MAIN, 0, 1'b0, 1, MAIN, "R6 back to main", -1, 0, 0);

        // R10: reserved request code
        @(negedge clk);
        mode_req = 2'd3;
        hold_quiet(20, MAIN, 3'b101, "R10 code 11 ignored");
        mode_req = 2'd0;

        // R11: stop during a transition is dropped
        run_wait(0, PLL, 0, 1'b0, 64, PLL, "R11 stop mid-switch", 5, 2, 0);
        hold_quiet(10, PLL, 3'b111, "R11 no stop after switch");

        // R11: stop in the same cycle as a new request loses
        run_wait(2, SUB, 0, 1'b1, 1, SUB, "R11 stop with request", -1, 0, 0);
        hold_quiet(10, SUB, 3'b001, "R11 still running on sub");

        // R7: sub stop, requests ignored while stopped, wake wait
        pulse_stop;
        @(negedge clk);
        mode_req = 2'd0;
        hold_quiet(20, SUB, 3'b000, "R7 stopped, request ignored");
        mode_req = 2'd2;
        run_wait(1, SUB, 3, 1'b1, 16, SUB, "R7 sub wake", -1, 0, 0);

        // R10: request changed during a long switch, then taken afterwards
        run_wait(0, PLL, 3, 1'b0, 256, PLL, "R10 target kept", 10, 1, MAIN);
        begin
            bit got;
            got = 1'b0;
            for (int i = 0; i < 10 && !got; i++) begin
                @(posedge clk);
                #1;
                if (src_sel == 2'(MAIN)) got = 1'b1;
            end
            check(got, "R10 pending request taken after done", src_sel, MAIN);
        end
        @(posedge clk);
        #1;

        // R9: main stop, wake without floor
        pulse_stop;
        check({main_osc_en, pll_en, sub_osc_en} == 3'b001, "R9 stop enables",
              {main_osc_en, pll_en, sub_osc_en}, 3'b001);
        run_wait(1, MAIN, 0, 1'b0, 4, MAIN, "R9 main wake", -1, 0, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule